// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block produces the timing and the per-pin drive-level codes for a passive LCD panel with four common lines and 80 segment lines. Each output is a 3-bit code that names one of five voltage levels. A separate analog stage turns each code into a voltage, and that stage is outside this block. The duty (static, 1/2, 1/3, 1/4) and the bias (1/2 or 1/3) are chosen at run time with plain select pins. The display data arrives as four 80-bit planes, one per common time slot. The planes are level inputs with no handshake, and the sequencer samples them continuously.

Frame timing advances only on `osc_tick`, a one-cycle enable pulse that marks each oscillator period. A frame lasts 24 ticks. The frame is split into equal slots, one for each active common. The drive polarity inverts from one frame to the next, so no pixel sees a net DC voltage.

For cascading, a master chip sends out a divided clock and an active-low frame-start sync. A slave chip keeps its common outputs at ground and realigns its frame counter to the master's sync. The block has no streaming interface, so it has no back-pressure rules.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: `duty_sel` selects the multiplex ratio: 0 is static (1 slot), 1 is 1/2 duty (2 slots), 2 is 1/3 duty (3 slots), 3 is 1/4 duty (4 slots). The 24-tick frame is divided into equal slots. The tick position `p` (0..23) lies in slot `p / (24/slots)`. Slot `s` uses segment plane `s`.
- R2: Common tying. In static mode all four commons carry the same code. In 1/2 duty, com index 0 and index 2 follow slot 0, and indices 1 and 3 follow slot 1. In 1/3 duty, com index `k` follows slot `k`, and index 3 repeats index 1. In 1/4 duty, com index `k` follows slot `k`.
- R3: Level codes are GND=0, VLCD/3=1, VLCD/2=2, 2VLCD/3=3, VLCD=4. A selected common, and every common in static mode, drives 4 in even frames and 0 in odd frames. With `bias_half`=0, an unselected common drives 1 in even frames and 3 in odd frames. With `bias_half`=1, it drives 2. Static mode ignores `bias_half`.
- R4: Segment `i` occupies `seg_lvl[3*i+2:3*i]` and takes its value from bit `i` of the current slot's plane. A lit segment drives 0 in even frames and 4 in odd frames. An unlit segment in static mode or at 1/2 bias drives 4 in even frames and 0 in odd frames. An unlit segment at 1/3 bias drives 3 in even frames and 1 in odd frames.
- R5: Polarity flips each time the position wraps from 23 to 0. The first frame after reset is even.
- R6: In master mode, `ck_out` is the tick count divided by 16: it is low for ticks 0..7 after reset and high for ticks 8..15. In slave mode, `ck_out` is held low.
- R7: In master mode, `sync_out_n` is low exactly while the position is 0. In slave mode, it is high.
- R8: In slave mode, all commons drive 0. A tick that arrives while `sync_in_n` is low sets the position to 1. If the position was not already 0, the polarity also flips.
- R9: When `disp_en` is 0, every common and every segment drives 0.
- R10: After reset, the position is 0, the polarity is even and `ck_out` is low.
- R11: Without `osc_tick`, position, polarity and every output code hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| is_master | input | 1 | 1 = master, 0 = slave |
| sync_in_n | input | 1 | Frame-start sync from the master (used by a slave) |
| duty_sel | input | 2 | Multiplex ratio select |
| bias_half | input | 1 | 1 = 1/2 bias, 0 = 1/3 bias |
| disp_en | input | 1 | Display enable |
| plane0 | input | 80 | Segment data for slot 0 |
| plane1 | input | 80 | Segment data for slot 1 |
| plane2 | input | 80 | Segment data for slot 2 |
| plane3 | input | 80 | Segment data for slot 3 |
| ck_out | output | 1 | Divided clock for cascaded chips |
| sync_out_n | output | 1 | Frame-start sync, active low |
| com_lvl | output | 12 | Four 3-bit common level codes, index 0 in the low bits |
| seg_lvl | output | 240 | Eighty 3-bit segment level codes |

## Verification
The hardest case to reach from the ports is a slave resync that arrives while the slave's own frame counter is out of step with the master. In that case the position jumps and the polarity flips in the same tick. The bench first runs the block as a master to a position in the middle of a frame. It then switches to slave mode and adds a few more ticks, so that the counter sits well away from zero. Only then does it hold `sync_in_n` low for one tick, with four distinct data planes at 1/4 duty. Every segment code then shows both the new slot and the new polarity, while the commons must stay at ground.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_COM = 4;

  typedef enum logic [LVL_W-1:0] {
    LV_GND  = 3'd0,
    LV_THIRD = 3'd1,
    LV_HALF = 3'd2,
    LV_TWO3 = 3'd3,
    LV_FULL = 3'd4
  } level_e;

  typedef enum logic [1:0] {
    DUTY_STATIC  = 2'd0,
    DUTY_HALF    = 2'd1,
    DUTY_THIRD   = 2'd2,
    DUTY_QUARTER = 2'd3
  } duty_e;
endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int FRAME_TICKS = 24,
  parameter int CK_DIV      = 16,
  localparam int POS_W      = $clog2(FRAME_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             is_master,
  input  logic             sync_in_n,
  output logic [POS_W-1:0] pos,
  output logic             pol,
  output logic             ck_out,
  output logic             sync_out_n
);
  localparam int DIV_W = $clog2(CK_DIV);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_TICKS - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      pol   <= 1'b0;
      div_q <= '0;
    end else if (osc_tick) begin
      div_q <= div_q + DIV_W'(1);
      if (!is_master && !sync_in_n) begin
        pos <= POS_W'(1);
        if (pos != '0) pol <= ~pol;
      end else if (pos == LAST) begin
        pos <= '0;
        pol <= ~pol;
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

  assign ck_out     = is_master & div_q[DIV_W-1];
  assign sync_out_n = ~(is_master && (pos == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> ($stable(pos) && $stable(pol)));

  // R5
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);

  // R5
  pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol) |-> (pos < POS_W'(2)));

  // R6
  ck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ck_out) && $stable(is_master)) |-> $past(osc_tick));

  // R7
  sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && osc_tick && pos == LAST) |=> (!sync_out_n || !is_master));
endmodule

// File: rtl/lcd_slot_decode.sv
module lcd_slot_decode
  import lcd_seq_pkg::*;
#(
  parameter int FRAME_TICKS = 24,
  localparam int POS_W      = $clog2(FRAME_TICKS)
) (
  input  duty_e            duty,
  input  logic [POS_W-1:0] pos,
  output logic [1:0]       slot
);
  localparam logic [POS_W-1:0] LEN2 = POS_W'(FRAME_TICKS / 2);
  localparam logic [POS_W-1:0] LEN3 = POS_W'(FRAME_TICKS / 3);
  localparam logic [POS_W-1:0] LEN4 = POS_W'(FRAME_TICKS / 4);

  always_comb begin
    unique case (duty)
      DUTY_STATIC: slot = 2'd0;
      DUTY_HALF:   slot = 2'(pos / LEN2);
      DUTY_THIRD:  slot = 2'(pos / LEN3);
      default:     slot = 2'(pos / LEN4);
    endcase
  end
endmodule

// File: rtl/lcd_com_driver.sv
module lcd_com_driver
  import lcd_seq_pkg::*;
(
  input  duty_e                      duty,
  input  logic [1:0]                 slot,
  input  logic                       pol,
  input  logic                       bias_half,
  input  logic                       is_master,
  input  logic                       disp_en,
  output logic [NUM_COM*LVL_W-1:0]   com_lvl
);
  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    localparam logic [1:0] KI = 2'(k);
    logic   sel;
    level_e lv;

    always_comb begin
      unique case (duty)
        DUTY_STATIC: sel = 1'b1;
        DUTY_HALF:   sel = (slot[0] == KI[0]);
        DUTY_THIRD:  sel = (KI == 2'd3) ? (slot == 2'd1) : (slot == KI);
        default:     sel = (slot == KI);
      endcase
    end

    always_comb begin
      if (!disp_en || !is_master) lv = LV_GND;
      else if (sel)               lv = pol ? LV_GND : LV_FULL;
      else if (bias_half)         lv = LV_HALF;
      else                        lv = pol ? LV_TWO3 : LV_THIRD;
    end

    assign com_lvl[k*LVL_W +: LVL_W] = lv;
  end
endmodule

// File: rtl/lcd_seg_driver.sv
module lcd_seg_driver
  import lcd_seq_pkg::*;
#(
  parameter int SEGS = 80
) (
  input  logic [3:0][SEGS-1:0]     planes,
  input  logic [1:0]               slot,
  input  logic                     pol,
  input  logic                     is_static,
  input  logic                     bias_half,
  input  logic                     disp_en,
  output logic [SEGS*LVL_W-1:0]    seg_lvl
);
  logic [SEGS-1:0] row;
  assign row = planes[slot];

  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    level_e lv;
    always_comb begin
      if (!disp_en)                   lv = LV_GND;
      else if (row[i])                lv = pol ? LV_FULL : LV_GND;
      else if (is_static || bias_half) lv = pol ? LV_GND : LV_FULL;
      else                            lv = pol ? LV_THIRD : LV_TWO3;
    end
    assign seg_lvl[i*LVL_W +: LVL_W] = lv;
  end
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int SEGS        = 80,
  parameter int FRAME_TICKS = 24,
  parameter int CK_DIV      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       osc_tick,
  input  logic                       is_master,
  input  logic                       sync_in_n,
  input  logic [1:0]                 duty_sel,
  input  logic                       bias_half,
  input  logic                       disp_en,
  input  logic [SEGS-1:0]            plane0,
  input  logic [SEGS-1:0]            plane1,
  input  logic [SEGS-1:0]            plane2,
  input  logic [SEGS-1:0]            plane3,
  output logic                       ck_out,
  output logic                       sync_out_n,
  output logic [NUM_COM*LVL_W-1:0]   com_lvl,
  output logic [SEGS*LVL_W-1:0]      seg_lvl
);
  localparam int POS_W = $clog2(FRAME_TICKS);

  duty_e               duty;
  logic [POS_W-1:0]    pos;
  logic                pol;
  logic [1:0]          slot;
  logic [3:0][SEGS-1:0] planes;

  assign duty   = duty_e'(duty_sel);
  assign planes = {plane3, plane2, plane1, plane0};

  lcd_frame_timer #(.FRAME_TICKS(FRAME_TICKS), .CK_DIV(CK_DIV)) i_timer (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .is_master(is_master),
    .sync_in_n(sync_in_n), .pos(pos), .pol(pol), .ck_out(ck_out),
    .sync_out_n(sync_out_n)
  );

  lcd_slot_decode #(.FRAME_TICKS(FRAME_TICKS)) i_slot (
    .duty(duty), .pos(pos), .slot(slot)
  );

  lcd_com_driver i_com (
    .duty(duty), .slot(slot), .pol(pol), .bias_half(bias_half),
    .is_master(is_master), .disp_en(disp_en), .com_lvl(com_lvl)
  );

  lcd_seg_driver #(.SEGS(SEGS)) i_seg (
    .planes(planes), .slot(slot), .pol(pol),
    .is_static(duty == DUTY_STATIC), .bias_half(bias_half),
    .disp_en(disp_en), .seg_lvl(seg_lvl)
  );

  // R8
  slave_com_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (com_lvl == '0));

  // R9
  dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (com_lvl == '0 && seg_lvl == '0));

  // R2
  tie_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == DUTY_HALF) |-> (com_lvl[8:6] == com_lvl[2:0] && com_lvl[11:9] == com_lvl[5:3]));

  // R2
  tie_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == DUTY_THIRD) |-> (com_lvl[11:9] == com_lvl[5:3]));

  // R2
  tie_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == DUTY_STATIC) |-> (com_lvl[5:3] == com_lvl[2:0] &&
      com_lvl[8:6] == com_lvl[2:0] && com_lvl[11:9] == com_lvl[2:0]));

  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((duty == DUTY_HALF) |-> (slot < 2'd2)) and ((duty == DUTY_THIRD) |-> (slot != 2'd3)));
endmodule

// File: tb/test_lcd_mux_sequencer.sv
`timescale 1ns/1ps
module test_lcd_mux_sequencer;
  localparam int SEGS = 80;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, osc_tick = 1'b0, is_master = 1'b1, sync_in_n = 1'b1;
  logic [1:0] duty_sel = 2'd3;
  logic bias_half = 1'b0, disp_en = 1'b1;
  logic [SEGS-1:0] pl [4];
  logic ck_out, sync_out_n;
  logic [11:0] com_lvl;
  logic [239:0] seg_lvl;

  lcd_mux_sequencer #(.SEGS(SEGS)) i_lcd_mux_sequencer (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .is_master(is_master),
    .sync_in_n(sync_in_n), .duty_sel(duty_sel), .bias_half(bias_half),
    .disp_en(disp_en), .plane0(pl[0]), .plane1(pl[1]), .plane2(pl[2]),
    .plane3(pl[3]), .ck_out(ck_out), .sync_out_n(sync_out_n),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  int checks = 0, errors = 0;
  int m_pos = 0, m_div = 0;
  bit m_pol = 1'b0;

  // duty, bias_half, ticks to advance before checking
  localparam logic [7:0] VEC [12] = '{
    {2'd0, 1'b0, 5'd1},  {2'd0, 1'b1, 5'd5},  {2'd1, 1'b0, 5'd6},
    {2'd1, 1'b0, 5'd6},  {2'd1, 1'b1, 5'd5},  {2'd2, 1'b0, 5'd8},
    {2'd2, 1'b0, 5'd8},  {2'd2, 1'b1, 5'd3},  {2'd3, 1'b0, 5'd6},
    {2'd3, 1'b0, 5'd6},  {2'd3, 1'b1, 5'd6},  {2'd3, 1'b0, 5'd13}
  };

  function automatic int slot_of(int duty, int pos);
    int n;
    n = duty + 1;
    return pos / (24 / n);
  endfunction

  function automatic logic [11:0] exp_com();
    logic [11:0] r;
    int s;
    bit sel;
    r = '0;
    s = slot_of(duty_sel, m_pos);
    for (int k = 0; k < 4; k++) begin
      case (duty_sel)
        2'd0: sel = 1'b1;
        2'd1: sel = ((k % 2) == s);
        2'd2: sel = (k == 3) ? (s == 1) : (k == s);
        default: sel = (k == s);
      endcase
      if (!disp_en || !is_master) r[k*3 +: 3] = 3'd0;
      else if (sel) r[k*3 +: 3] = m_pol ? 3'd0 : 3'd4;
      else if (bias_half) r[k*3 +: 3] = 3'd2;
      else r[k*3 +: 3] = m_pol ? 3'd3 : 3'd1;
    end
    return r;
  endfunction

  function automatic logic [239:0] exp_seg();
    logic [239:0] r;
    int s;
    r = '0;
    s = slot_of(duty_sel, m_pos);
    for (int i = 0; i < SEGS; i++) begin
      if (!disp_en) r[i*3 +: 3] = 3'd0;
      else if (pl[s][i]) r[i*3 +: 3] = m_pol ? 3'd4 : 3'd0;
      else if (duty_sel == 2'd0 || bias_half) r[i*3 +: 3] = m_pol ? 3'd0 : 3'd4;
      else r[i*3 +: 3] = m_pol ? 3'd1 : 3'd3;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [239:0] act, input logic [239:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) osc_tick = 1'b1;
    @(negedge clk) osc_tick = 1'b0;
    m_div = (m_div + 1) % 16;
    if (!is_master && !sync_in_n) begin
      if (m_pos != 0) m_pol = ~m_pol;
      m_pos = 1;
    end else if (m_pos == 23) begin
      m_pos = 0;
      m_pol = ~m_pol;
    end else begin
      m_pos++;
    end
    #1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [11:0]  hold_com;
  logic [239:0] hold_seg;

  initial begin
    pl[0] = {10{8'hC3}};
    pl[1] = {20{4'h9}};
    pl[2] = {40{2'b10}};
    pl[3] = {16{5'b10110}};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10 ck_out", 240'(ck_out), 240'(0));
    check("R10 sync_out_n", 240'(sync_out_n), 240'(0));
    check("R10 com", 240'(com_lvl), 240'(exp_com()));

    // R6 divided clock
    repeat (7) tick();
    check("R6 ck_out after 7", 240'(ck_out), 240'(0));
    check("R7 sync high mid-frame", 240'(sync_out_n), 240'(1));
    tick();
    check("R6 ck_out after 8", 240'(ck_out), 240'(1));
    repeat (8) tick();
    check("R6 ck_out after 16", 240'(ck_out), 240'(0));
    repeat (8) tick();
    // position now 0 of the second frame
    check("R7 sync low at frame start", 240'(sync_out_n), 240'(0));
    check("R5 odd-frame com", 240'(com_lvl), 240'(exp_com()));
    check("R5 odd-frame pol model", 240'(m_pol), 240'(1));

    for (int v = 0; v < 12; v++) begin
      duty_sel  = VEC[v][7:6];
      bias_half = VEC[v][5];
      repeat (int'(VEC[v][4:0])) tick();
      check($sformatf("R1 R2 R3 com vec %0d", v), 240'(com_lvl), 240'(exp_com()));
      check($sformatf("R1 R4 seg vec %0d", v), seg_lvl, exp_seg());
    end

    // R11 no ticks, nothing moves
    hold_com = com_lvl;
    hold_seg = seg_lvl;
    repeat (20) @(negedge clk);
    #1;
    check("R11 com hold", 240'(com_lvl), 240'(hold_com));
    check("R11 seg hold", seg_lvl, hold_seg);

    // R9 display off
    disp_en = 1'b0;
    tick();
    check("R9 com dark", 240'(com_lvl), 240'(0));
    check("R9 seg dark", seg_lvl, 240'(0));
    disp_en = 1'b1;

    // R8 slave: commons at ground, resync from a misaligned phase
    duty_sel = 2'd3;
    bias_half = 1'b0;
    repeat (5) tick();
    is_master = 1'b0;
    repeat (3) tick();
    check("R8 slave com gnd", 240'(com_lvl), 240'(0));
    check("R6 slave ck_out low", 240'(ck_out), 240'(0));
    check("R7 slave sync high", 240'(sync_out_n), 240'(1));
    sync_in_n = 1'b0;
    tick();
    sync_in_n = 1'b1;
    check("R8 resync pos model", 240'(m_pos), 240'(1));
    check("R8 resync seg", seg_lvl, exp_seg());
    repeat (6) tick();
    check("R8 after resync slot1 seg", seg_lvl, exp_seg());
    is_master = 1'b1;
    #1;
    check("R3 master again com", 240'(com_lvl), 240'(exp_com()));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule